// File: doc/BRIEF.md
# Converter Output Timing Aligner

This block sits between the digital side of a 10-bit pipelined converter and a three-state output bus. Words arrive on the conversion clock. The block holds them long enough to match the converter's pipeline latency, which depends on the mode. It then launches them from the conversion clock or from a separate output clock, on the edge that is selected. The bus is released to high impedance when any disable source asks for it.

The capture edge follows the clock polarity setting. Normally a word is taken on the falling edge of the conversion clock and leaves on a rising edge 5.5 periods later. With the clock inverted, the word is taken on the rising edge and leaves 6.0 periods later. When the direct input feeds the gain stage, the output is held back by two more periods. A blanking flag travels through the same delay as the data. When it reaches the output, the programmed black target code is shown in place of the pixel word.

The mode bits come in through a two-flop synchronizer. The standby pin acts on the output enable at once.

Top module: `adc_out_aligner`

## Requirements
- R1: Outside blanking the bus carries the captured code unchanged in straight binary: code 0 stays 0 and full scale (all ten bits 1, 0x3FF) stays 0x3FF.
- R2: With `conv_invert`=0 and `path_gain`=0, a word is taken on a falling edge of `clk_conv` and appears after the sixth following rising edge (5.5 periods).
- R3: With `conv_invert`=1, a word is taken on a rising edge of `clk_conv` and appears after the sixth rising edge that follows it (6.0 periods).
- R4: With `path_gain`=1, the delay of R2 or R3 grows by exactly two `clk_conv` periods.
- R5: With `use_out_clk`=0 the bus changes on `clk_conv` rising edges. With `use_out_clk`=1 it is re-registered on `clk_out`: on its rising edge when `out_edge_fall`=0, and on its falling edge when `out_edge_fall`=1.
- R6: A word that was captured with `blank`=1 is shown as `black_code`, with the same latency as the data.
- R7: `out_disable`=1 drives `dout_oe` low by the third `clk_conv` rising edge; returning it to 0 sets `dout_oe` high again.
- R8: `pwr_down`=1 drives `dout_oe` low by the third `clk_conv` rising edge; returning it to 0 sets `dout_oe` high again.
- R9: `standby_n`=0 drives `dout_oe` low at once, with no clock edge needed.
- R10: After a synchronous reset the bus reads 0 and, with `standby_n`=1 and both disable bits at 0, `dout_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_conv | input | 1 | Conversion clock |
| clk_out | input | 1 | Optional separate output clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_invert | input | 1 | Conversion clock polarity inversion |
| path_gain | input | 1 | Direct input routed through the gain stage (adds two periods) |
| use_out_clk | input | 1 | 0: launch on clk_conv, 1: launch on clk_out |
| out_edge_fall | input | 1 | With clk_out launch: 0 rising edge, 1 falling edge |
| out_disable | input | 1 | Output disable bit |
| pwr_down | input | 1 | Power-down bit |
| standby_n | input | 1 | Standby pin, active low |
| blank | input | 1 | Blanking flag that travels with the sample |
| black_code | input | 10 | Black target code |
| sample | input | 10 | Converted sample code |
| dout | output | 10 | Output data bus |
| dout_oe | output | 1 | Bus output enable (0 = high impedance) |

## Verification
The assertions assume that the mode bits stay still long enough for the two-flop synchronizer to settle, and that `clk_out` and `clk_conv` have a fixed phase, so that a crossing word is stable when the other domain samples it. The stimulus changes a mode only between runs. It then lets several conversion periods pass before it compares any output. The samples are driven one time unit after a rising edge, away from both conversion clock edges. The output clock runs at the same rate, with its edges 2 and 6 time units after the conversion rising edge.

// File: rtl/aoa_pkg.sv
package aoa_pkg;

    localparam int CODE_W     = 10;
    localparam int BASE_LAT   = 6;
    localparam int GAIN_EXTRA = 2;
    localparam logic [CODE_W-1:0] BLACK_DEFAULT = CODE_W'(64);

    typedef struct packed {
        logic              blank;
        logic [CODE_W-1:0] code;
    } smp_t;

    typedef struct packed {
        logic              use_out;
        logic              edge_fall;
        logic              inv;
        logic              gain;
        logic              out_dis;
        logic              pwr_dn;
        logic [CODE_W-1:0] black;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    localparam mode_t MODE_INIT = '{
        use_out:   1'b0,
        edge_fall: 1'b0,
        inv:       1'b0,
        gain:      1'b0,
        out_dis:   1'b0,
        pwr_dn:    1'b0,
        black:     BLACK_DEFAULT
    };

    function automatic logic [CODE_W-1:0] present_code(smp_t s, logic [CODE_W-1:0] black);
        return s.blank ? black : s.code;
    endfunction

endpackage

// File: rtl/aoa_sync.sv
module aoa_sync #(
    parameter int               WIDTH = 1,
    parameter logic [WIDTH-1:0] INIT  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= INIT;
            hold_q <= INIT;
        end else begin
            meta_q <= d;
            hold_q <= meta_q;
        end
    end

    assign q = hold_q;
endmodule

// File: rtl/aoa_capture.sv
module aoa_capture
    import aoa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic inv,
    input  smp_t din,
    output smp_t cap
);
    smp_t fall_q;
    smp_t rise_q;

    // normal polarity: converter hands the word over on the falling edge
    always_ff @(negedge clk) begin
        if (rst) fall_q <= '0;
        else     fall_q <= din;
    end

    // inverted polarity: the hand-over edge is the raw rising edge
    always_ff @(posedge clk) begin
        if (rst) rise_q <= '0;
        else     rise_q <= din;
    end

    assign cap = inv ? rise_q : fall_q;
endmodule

// File: rtl/aoa_delay.sv
module aoa_delay
    import aoa_pkg::*;
#(
    parameter int LAT   = BASE_LAT,
    parameter int EXTRA = GAIN_EXTRA
) (
    input  logic clk,
    input  logic rst,
    input  logic gain,
    input  smp_t din,
    output smp_t head,
    output smp_t base,
    output smp_t tap
);
    localparam int BASE_IDX = LAT - 2;
    localparam int DEPTH    = LAT - 1 + EXTRA;
    localparam int LONG_IDX = DEPTH - 1;

    smp_t stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign head = stg[0];
    assign base = stg[BASE_IDX];

    generate
        if (EXTRA == 0) begin : g_no_extra
            assign tap = stg[BASE_IDX];
        end else begin : g_extra
            assign tap = gain ? stg[LONG_IDX] : stg[BASE_IDX];
        end
    endgenerate
endmodule

// File: rtl/aoa_launch.sv
module aoa_launch #(
    parameter int W = 10
) (
    input  logic         clk_out,
    input  logic         rst,
    input  logic         use_out,
    input  logic         edge_fall,
    input  logic [W-1:0] word,
    output logic [W-1:0] dout
);
    logic [W-1:0] rise_q;
    logic [W-1:0] fall_q;

    always_ff @(posedge clk_out) begin
        if (rst) rise_q <= '0;
        else     rise_q <= word;
    end

    always_ff @(negedge clk_out) begin
        if (rst) fall_q <= '0;
        else     fall_q <= word;
    end

    always_comb begin
        if (!use_out)       dout = word;
        else if (edge_fall) dout = fall_q;
        else                dout = rise_q;
    end
endmodule

// File: rtl/adc_out_aligner.sv
module adc_out_aligner
    import aoa_pkg::*;
#(
    parameter int LATENCY    = BASE_LAT,
    parameter int GAIN_DELAY = GAIN_EXTRA
) (
    input  logic              clk_conv,
    input  logic              clk_out,
    input  logic              rst,
    input  logic              conv_invert,
    input  logic              path_gain,
    input  logic              use_out_clk,
    input  logic              out_edge_fall,
    input  logic              out_disable,
    input  logic              pwr_down,
    input  logic              standby_n,
    input  logic              blank,
    input  logic [CODE_W-1:0] black_code,
    input  logic [CODE_W-1:0] sample,
    output logic [CODE_W-1:0] dout,
    output logic              dout_oe
);
    mode_t mode_in;
    mode_t mode_s;
    smp_t  in_word;
    smp_t  cap_word;
    smp_t  head_word;
    smp_t  base_word;
    smp_t  tap_word;
    logic [CODE_W-1:0] conv_word;
    logic [1:0]        warm;

    always_comb begin
        mode_in.use_out   = use_out_clk;
        mode_in.edge_fall = out_edge_fall;
        mode_in.inv       = conv_invert;
        mode_in.gain      = path_gain;
        mode_in.out_dis   = out_disable;
        mode_in.pwr_dn    = pwr_down;
        mode_in.black     = black_code;
        in_word.blank     = blank;
        in_word.code      = sample;
    end

    aoa_sync #(.WIDTH(MODE_W), .INIT(MODE_INIT)) u_mode_sync (
        .clk (clk_conv),
        .rst (rst),
        .d   (mode_in),
        .q   (mode_s)
    );

    aoa_capture u_capture (
        .clk (clk_conv),
        .rst (rst),
        .inv (mode_s.inv),
        .din (in_word),
        .cap (cap_word)
    );

    aoa_delay #(.LAT(LATENCY), .EXTRA(GAIN_DELAY)) u_delay (
        .clk  (clk_conv),
        .rst  (rst),
        .gain (mode_s.gain),
        .din  (cap_word),
        .head (head_word),
        .base (base_word),
        .tap  (tap_word)
    );

    always_ff @(posedge clk_conv) begin
        if (rst) conv_word <= '0;
        else     conv_word <= present_code(tap_word, mode_s.black);
    end

    aoa_launch #(.W(CODE_W)) u_launch (
        .clk_out   (clk_out),
        .rst       (rst),
        .use_out   (mode_s.use_out),
        .edge_fall (mode_s.edge_fall),
        .word      (conv_word),
        .dout      (dout)
    );

    assign dout_oe = standby_n & ~mode_s.out_dis & ~mode_s.pwr_dn;

    always_ff @(posedge clk_conv) begin
        if (rst)               warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    AST_STBY_HIZ: assert property (@(posedge clk_conv) disable iff (rst)
        !standby_n |-> !dout_oe)
        else $error("standby pin low yet bus enabled"); // R9

    AST_DIS_HIZ: assert property (@(posedge clk_conv) disable iff (rst)
        (warm == 2'd3 && $past(out_disable, 2)) |-> !dout_oe)
        else $error("disable bit set yet bus enabled"); // R7

    AST_PD_HIZ: assert property (@(posedge clk_conv) disable iff (rst)
        (warm == 2'd3 && $past(pwr_down, 2)) |-> !dout_oe)
        else $error("power-down bit set yet bus enabled"); // R8

    AST_INV_CAPTURE: assert property (@(posedge clk_conv) disable iff (rst)
        (warm == 2'd3 && mode_s.inv && $past(mode_s.inv)) |-> head_word == $past(in_word, 2))
        else $error("inverted capture edge misaligned"); // R3

    AST_GAIN_EXTRA: assert property (@(posedge clk_conv) disable iff (rst)
        (warm == 2'd3 && mode_s.gain) |-> tap_word == $past(base_word, 2))
        else $error("gain path extra delay wrong"); // R4

    AST_BLANK_SUB: assert property (@(posedge clk_conv) disable iff (rst)
        (warm == 2'd3 && !mode_s.use_out && $past(tap_word.blank) && $stable(mode_s.black))
            |-> dout == mode_s.black)
        else $error("blanked word not replaced by black code"); // R6
endmodule

// File: tb/adc_out_aligner_tb.sv
module adc_out_aligner_tb_top;

    typedef struct packed {
        logic       use_out;
        logic       edge_fall;
        logic       inv;
        logic       gain;
        logic [9:0] black;
        logic [7:0] seed;
    } row_t;

    localparam int NROWS = 7;
    localparam int NSTEP = 22;
    localparam row_t ROWS [NROWS] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 10'd64,  8'd3},
        '{1'b0, 1'b0, 1'b1, 1'b0, 10'd16,  8'd5},
        '{1'b0, 1'b0, 1'b0, 1'b1, 10'd127, 8'd7},
        '{1'b0, 1'b0, 1'b1, 1'b1, 10'd100, 8'd11},
        '{1'b1, 1'b0, 1'b0, 1'b0, 10'd64,  8'd13},
        '{1'b1, 1'b1, 1'b1, 1'b1, 10'd20,  8'd17},
        '{1'b1, 1'b1, 1'b0, 1'b0, 10'd33,  8'd19}
    };

    logic       clk_conv = 1'b0;
    logic       clk_out  = 1'b0;
    logic       rst = 1'b1;
    logic       conv_invert = 1'b0;
    logic       path_gain = 1'b0;
    logic       use_out_clk = 1'b0;
    logic       out_edge_fall = 1'b0;
    logic       out_disable = 1'b0;
    logic       pwr_down = 1'b0;
    logic       standby_n = 1'b1;
    logic       blank = 1'b0;
    logic [9:0] black_code = 10'd64;
    logic [9:0] sample = '0;
    logic [9:0] dout;
    logic       dout_oe;

    int checks = 0;
    int fails  = 0;
    logic [9:0] expv [NSTEP];

    always #4 clk_conv = ~clk_conv;
    initial begin
        #6;
        forever begin
            clk_out = 1'b1;
            #4;
            clk_out = 1'b0;
            #4;
        end
    end

    adc_out_aligner dut_i (
        .clk_conv(clk_conv), .clk_out(clk_out), .rst(rst),
        .conv_invert(conv_invert), .path_gain(path_gain),
        .use_out_clk(use_out_clk), .out_edge_fall(out_edge_fall),
        .out_disable(out_disable), .pwr_down(pwr_down), .standby_n(standby_n),
        .blank(blank), .black_code(black_code), .sample(sample),
        .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] code_of(int n, int seed);
        if (n % 8 == 0) return 10'h000;
        if (n % 8 == 1) return 10'h3FF;
        return 10'((n * 29 * seed + seed * 7) % 1024);
    endfunction

    function automatic logic blank_of(int n, int seed);
        return ((n + seed) % 5) == 2;
    endfunction

    task automatic idle(input int cyc);
        for (int i = 0; i < cyc; i++) begin
            @(posedge clk_conv);
            #1;
            sample = '0;
            blank  = 1'b0;
        end
    endtask

    // R2 R3 R4: latency in rising edges from drive slot to visible output
    task automatic run_row(input row_t r);
        int d;
        string tag;
        @(posedge clk_conv);
        #1;
        use_out_clk   = r.use_out;
        out_edge_fall = r.edge_fall;
        conv_invert   = r.inv;
        path_gain     = r.gain;
        black_code    = r.black;
        idle(5);
        d = 6 + (r.inv ? 1 : 0) + (r.gain ? 2 : 0);
        tag = r.gain ? "R4" : (r.inv ? "R3" : "R2");
        for (int n = 0; n < NSTEP; n++) begin
            @(posedge clk_conv);
            #1;
            sample  = code_of(n, int'(r.seed));
            blank   = blank_of(n, int'(r.seed));
            expv[n] = blank ? r.black : sample;
            #2;
            // R5: between output-clock edges the chosen edge decides
            if (r.use_out && n - 1 - d >= 0)
                chk($sformatf("R5 edge n=%0d", n), dout,
                    r.edge_fall ? expv[n-1-d] : expv[n-d]);
            #4;
            if (n - d >= 0) begin
                chk($sformatf("%s %s n=%0d", tag,
                    blank_of(n - d, int'(r.seed)) ? "R6" : "R1", n), dout, expv[n-d]);
                chk("R10 oe during stream", {9'd0, dout_oe}, 10'd1);
            end
        end
    endtask

    initial begin
        repeat (6) @(posedge clk_conv);
        #1;
        rst = 1'b0;
        #6;
        // R10: reset state
        chk("R10 reset dout", dout, 10'd0);
        chk("R10 reset oe", {9'd0, dout_oe}, 10'd1);

        for (int r = 0; r < NROWS; r++) run_row(ROWS[r]);

        @(posedge clk_conv);
        #1;
        use_out_clk = 1'b0;
        out_edge_fall = 1'b0;
        conv_invert = 1'b0;
        path_gain = 1'b0;

        // R7: output disable bit
        out_disable = 1'b1;
        idle(3);
        #6;
        chk("R7 disable hiz", {9'd0, dout_oe}, 10'd0);
        @(posedge clk_conv);
        #1;
        out_disable = 1'b0;
        idle(3);
        #6;
        chk("R7 disable release", {9'd0, dout_oe}, 10'd1);

        // R8: power-down bit
        @(posedge clk_conv);
        #1;
        pwr_down = 1'b1;
        idle(3);
        #6;
        chk("R8 powerdown hiz", {9'd0, dout_oe}, 10'd0);
        @(posedge clk_conv);
        #1;
        pwr_down = 1'b0;
        idle(3);
        #6;
        chk("R8 powerdown release", {9'd0, dout_oe}, 10'd1);

        // R9: standby pin acts without a clock edge
        @(posedge clk_conv);
        #1;
        standby_n = 1'b0;
        #1;
        chk("R9 standby hiz", {9'd0, dout_oe}, 10'd0);
        standby_n = 1'b1;
        #1;
        chk("R9 standby release", {9'd0, dout_oe}, 10'd1);

        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_conv);
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule